// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs external memory cycles on behalf of a 16-bit core. The core presents a byte address, write data, byte enables and a read/write flag while the sequencer is idle. The sequencer then steps through an address phase, an optional delay phase, a strobe phase and an optional release phase. It drives the address latch enable, the active-low read and write strobes, and the port enables. At the end it returns a one-clock done pulse together with any read data.

The external bus has four shapes: data 8 or 16 bits wide, with the address either on a dedicated port (demultiplexed) or sent ahead of the data on the shared port (multiplexed). A fifth setting disables external cycles altogether. The configuration inputs set the phase lengths: a short or long latch pulse, 0 to 15 wait clocks, an extra read/write delay clock and an extra release clock. An external ready input stretches the strobe. The configuration is captured when a request is accepted, so each cycle keeps its own timing. The upper address lines can be cut down to fit a smaller external space.

Top module: `ext_bus_seq`

## Requirements
- R1: `cfg_mode` selects the bus: 1 = 16-bit demultiplexed, 2 = 16-bit multiplexed, 3 = 8-bit multiplexed, 4 = 8-bit demultiplexed. Values 0 and 5 to 7 mean single-chip: requests are not accepted, and no latch pulse, strobe or done pulse appears.
- R2: In demultiplexed modes, `addr_lo` carries the cycle address and `addr_oe` is high for every phase. Written data appears on `ad_out`. In 8-bit demultiplexed mode only `ad_out[7:0]` carries data and bits 15:8 are zero.
- R3: In multiplexed modes, `addr_oe` stays low. During the latch phase, `ad_out` carries the low 16 address bits with `ad_oe` high. Written data follows on the same port.
- R4: The latch phase (`ale` high, strobes inactive) lasts 1 clock, or 2 clocks when `cfg_ale_long` is set.
- R5: With ready high, the strobe is low for `cfg_wait`+1 clocks. A read lowers `rd_n` only, and a write lowers `wr_n` only.
- R6: After the wait clocks, the strobe stays low on every clock in which `ext_ready` is sampled low. It ends at the first clock edge at which `ext_ready` is high.
- R7: `cfg_rw_delay` adds one clock between the latch phase and the strobe. `cfg_tri_hold` adds one clock after the strobe. The total cycle length is latch + delay + strobe + release clocks.
- R8: `addr_hi` carries address bits 23:16 masked by `cfg_space`: 0 leaves no lines (all zero), 1 leaves bits 17:16, 2 leaves bits 19:16, and 3 leaves all eight.
- R9: On an 8-bit bus, byte enables 01 give one cycle at the even address, and 10 give one cycle at the odd address carrying the high data byte. Any other value gives two consecutive cycles, even byte first. Read bytes return in their own lanes of `req_rdata`, and lanes not read are zero.
- R10: `req_done` is high for exactly one clock after the last phase of a request, with `req_rdata` valid in that clock. Requests, and configuration changes, that arrive while `req_idle` is low have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 low byte) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idle | output | 1 | Sequencer can take a request |
| req_done | output | 1 | One-clock end-of-request pulse |
| req_rdata | output | 16 | Read data, valid with req_done |
| cfg_mode | input | 3 | Bus mode (R1 encoding) |
| cfg_wait | input | WW | Wait clocks in the strobe |
| cfg_ale_long | input | 1 | Two-clock latch phase |
| cfg_rw_delay | input | 1 | Extra clock before the strobe |
| cfg_tri_hold | input | 1 | Extra clock after the strobe |
| cfg_space | input | 2 | External space size (R8 encoding) |
| ext_ready | input | 1 | External ready |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_lo | output | 16 | Dedicated address port |
| addr_oe | output | 1 | Dedicated address port enable |
| addr_hi | output | 8 | Upper address lines |
| ad_out | output | 16 | Shared address/data port output |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 16 | Shared port input |

## Verification
The assertions assume that `ext_ready` is a clean synchronous level and that `cfg_mode` is stable in any clock in which a request is offered. The bench models the external device on the falling clock edge. It holds ready low for a chosen number of clocks beyond the programmed wait and then raises it. It changes the configuration only while the block is idle, except in the one scenario that tests whether a mid-cycle change is ignored.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [23:0]   req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  input  logic          req_write,
  output logic          req_idle,
  output logic          req_done,
  output logic [15:0]   req_rdata,
  input  logic [2:0]    cfg_mode,
  input  logic [WW-1:0] cfg_wait,
  input  logic          cfg_ale_long,
  input  logic          cfg_rw_delay,
  input  logic          cfg_tri_hold,
  input  logic [1:0]    cfg_space,
  input  logic          ext_ready,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [15:0]   addr_lo,
  output logic          addr_oe,
  output logic [7:0]    addr_hi,
  output logic [15:0]   ad_out,
  output logic          ad_oe,
  input  logic [15:0]   ad_in
);
  typedef enum logic [2:0] {S_IDLE, S_ALE, S_DLY, S_STB, S_TRI} phase_t;

  phase_t        st;
  logic [WW-1:0] cnt, wt;
  logic          hi, both, wr, mux, b8, a2, dl, tr;
  logic [1:0]    sp;
  logic [23:0]   addr;
  logic [15:0]   wd;

  wire ext_mode = (cfg_mode >= 3'd1) && (cfg_mode <= 3'd4);
  wire new_b8   = (cfg_mode == 3'd3) || (cfg_mode == 3'd4);
  wire accept   = (st == S_IDLE) && req_valid && ext_mode;
  wire stb_end  = (st == S_STB) && (cnt == wt) && ext_ready;
  wire fin      = (st == S_TRI) || (stb_end && !tr);
  wire busy     = (st != S_IDLE);
  wire [23:0] cyc_a = {addr[23:1], b8 & hi};
  wire [7:0]  wbyte = hi ? wd[15:8] : wd[7:0];
  wire [15:0] wbus  = b8 ? {8'h00, wbyte} : wd;
  wire        wdrv  = wr && (st == S_DLY || st == S_STB || st == S_TRI);

  logic [7:0] hi_mask;
  always_comb begin
    case (sp)
      2'd0:    hi_mask = 8'h00;
      2'd1:    hi_mask = 8'h03;
      2'd2:    hi_mask = 8'h0f;
      default: hi_mask = 8'hff;
    endcase
  end

  assign req_idle = !busy;
  assign ale      = (st == S_ALE);
  assign rd_n     = !((st == S_STB) && !wr);
  assign wr_n     = !((st == S_STB) && wr);
  assign addr_oe  = busy && !mux;
  assign addr_lo  = addr_oe ? cyc_a[15:0] : 16'h0000;
  assign addr_hi  = busy ? (cyc_a[23:16] & hi_mask) : 8'h00;
  assign ad_oe    = (ale && mux) || wdrv;
  assign ad_out   = (ale && mux) ? cyc_a[15:0] : (wdrv ? wbus : 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wt <= '0;
      hi <= 1'b0; both <= 1'b0; wr <= 1'b0; mux <= 1'b0; b8 <= 1'b0;
      a2 <= 1'b0; dl <= 1'b0; tr <= 1'b0; sp <= 2'd0;
      addr <= '0; wd <= '0; req_rdata <= '0; req_done <= 1'b0;
    end else begin
      req_done <= 1'b0;
      if (accept) begin
        st <= S_ALE; cnt <= '0; wt <= cfg_wait;
        a2 <= cfg_ale_long; dl <= cfg_rw_delay; tr <= cfg_tri_hold; sp <= cfg_space;
        mux <= (cfg_mode == 3'd2) || (cfg_mode == 3'd3);
        b8 <= new_b8; wr <= req_write; addr <= req_addr; wd <= req_wdata;
        hi <= new_b8 && (req_be == 2'b10);
        both <= new_b8 && (req_be != 2'b01) && (req_be != 2'b10);
        req_rdata <= '0;
      end else begin
        case (st)
          S_ALE: begin
            if (a2 && cnt == '0) cnt <= cnt + 1'b1;
            else begin
              st <= dl ? S_DLY : S_STB;
              cnt <= '0;
            end
          end
          S_DLY: st <= S_STB;
          S_STB: begin
            if (cnt != wt) cnt <= cnt + 1'b1;
            else if (ext_ready) begin
              if (!wr) begin
                if (!b8) req_rdata <= ad_in;
                else if (hi) req_rdata[15:8] <= ad_in[7:0];
                else req_rdata[7:0] <= ad_in[7:0];
              end
              if (tr) st <= S_TRI;
            end
          end
          default: ;
        endcase
        if (fin) begin
          cnt <= '0;
          if (both && !hi) begin
            hi <= 1'b1;
            st <= S_ALE;
          end else begin
            st <= S_IDLE;
            req_done <= 1'b1;
          end
        end
      end
    end
  end

  assert_single_chip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_idle && req_valid && (cfg_mode == 3'd0)) |=> req_idle);
  assert_mux_addr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !addr_oe) |-> ad_oe);
  assert_ale_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));
  assert_ready_hold_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !ext_ready) |=> !rd_n);
  assert_ready_hold_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !ext_ready) |=> !wr_n);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
endmodule

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic [2:0]  cfg_mode = 3'd0;
  logic [3:0]  cfg_wait = '0;
  logic cfg_ale_long = 1'b0, cfg_rw_delay = 1'b0, cfg_tri_hold = 1'b0;
  logic [1:0]  cfg_space = 2'd3;
  logic ext_ready = 1'b1;
  logic req_idle, req_done, ale, rd_n, wr_n, addr_oe, ad_oe;
  logic [15:0] req_rdata, addr_lo, ad_out, ad_in;
  logic [7:0]  addr_hi;

  int total = 0, bad = 0;
  int n, ale_cnt, stb_cnt, pulses, done_after;
  logic [15:0] ale_ad [2];
  logic [15:0] s_alo, s_ad, rdata_done;
  logic [7:0]  s_ahi;
  logic s_aoe, s_adoe;

  always #10 clk = ~clk;

  assign ad_in = (pulses <= 1) ? 16'hA1B2 : 16'hC3D4;

  ext_bus_seq uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [23:0] a, input logic [15:0] d,
                      input logic [1:0] be, input int w, input int xtra, input bit intrude);
    int j = 0, ales = 0;
    logic pstb = 1'b0, pale = 1'b0;
    n = 0; ale_cnt = 0; stb_cnt = 0; pulses = 0; done_after = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_done && n < 300) begin
      logic stb;
      stb = !rd_n || !wr_n;
      if (ale) ale_cnt++;
      if (ale && !pale && ales < 2) begin ale_ad[ales] = ad_out; ales++; end
      if (stb) stb_cnt++;
      if (stb && !pstb) begin
        pulses++;
        s_alo = addr_lo; s_ahi = addr_hi; s_ad = ad_out; s_aoe = addr_oe; s_adoe = ad_oe;
      end
      j = stb ? j + 1 : 0;
      ext_ready = !stb || (j >= w + 1 + xtra);
      pstb = stb; pale = ale;
      if (intrude && n == 2) begin
        req_valid = 1'b1; req_addr = 24'h00ABCD; cfg_wait = 4'd0;
      end
      if (intrude && n == 3) req_valid = 1'b0;
      n++;
      @(negedge clk);
    end
    ext_ready = 1'b1;
    if (n >= 300) chk("R10 done never seen", 0, 1);
    rdata_done = req_rdata;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (req_done || ale || !rd_n || !wr_n) done_after++;
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [3:0] w, input logic al,
                         input logic dly, input logic th, input logic [1:0] sp);
    cfg_mode = m; cfg_wait = w; cfg_ale_long = al; cfg_rw_delay = dly;
    cfg_tri_hold = th; cfg_space = sp;
  endtask

  task automatic t_reset;
    chk("R10 reset idle", req_idle, 1);
    chk("R10 reset done", req_done, 0);
    chk("R5 reset strobes", {rd_n, wr_n, ale}, 3'b110);
    chk("R2 reset enables", {addr_oe, ad_oe}, 2'b00);
  endtask

  task automatic t_demux16_read;
    set_cfg(3'd1, 4'd2, 0, 0, 0, 2'd3);
    xfer(0, 24'h5A1234, 16'h0, 2'b11, 2, 0, 0);
    chk("R7 demux16 length", n, 4);
    chk("R5 demux16 strobe clocks", stb_cnt, 3);
    chk("R4 short latch", ale_cnt, 1);
    chk("R2 demux address", s_alo, 16'h1234);
    chk("R2 demux addr_oe", s_aoe, 1);
    chk("R8 full space", s_ahi, 8'h5A);
    chk("R10 read data", rdata_done, 16'hA1B2);
    chk("R10 single done", done_after, 0);
  endtask

  task automatic t_mux16_write;
    set_cfg(3'd2, 4'd1, 1, 1, 1, 2'd1);
    xfer(1, 24'h5B8766, 16'hBEEF, 2'b11, 1, 0, 0);
    chk("R7 delay+release length", n, 6);
    chk("R4 long latch", ale_cnt, 2);
    chk("R3 address on shared port", ale_ad[0], 16'h8766);
    chk("R3 no dedicated port", s_aoe, 0);
    chk("R3 write data", s_ad, 16'hBEEF);
    chk("R3 data enable", s_adoe, 1);
    chk("R8 two lines", s_ahi, 8'h03);
    chk("R5 write strobe clocks", stb_cnt, 2);
  endtask

  task automatic t_mux8_word_read;
    set_cfg(3'd3, 4'd0, 0, 0, 0, 2'd2);
    xfer(0, 24'h3C4450, 16'h0, 2'b11, 0, 0, 0);
    chk("R9 two byte cycles", pulses, 2);
    chk("R9 split length", n, 4);
    chk("R9 first byte even", ale_ad[0], 16'h4450);
    chk("R9 second byte odd", ale_ad[1], 16'h4451);
    chk("R9 lanes", rdata_done, 16'hD4B2);
    chk("R8 four lines", s_ahi, 8'h0C);
  endtask

  task automatic t_demux8_hi_write;
    set_cfg(3'd4, 4'd3, 0, 0, 0, 2'd0);
    xfer(1, 24'h7F1000, 16'h7788, 2'b10, 3, 0, 0);
    chk("R9 single high byte", pulses, 1);
    chk("R7 demux8 length", n, 5);
    chk("R9 odd address", s_alo, 16'h1001);
    chk("R2 low lane only", s_ad, 16'h0077);
    chk("R8 no lines", s_ahi, 8'h00);
  endtask

  task automatic t_demux8_lo_read;
    set_cfg(3'd4, 4'd0, 0, 0, 0, 2'd3);
    xfer(0, 24'h000201, 16'h0, 2'b01, 0, 0, 0);
    chk("R9 single low byte", pulses, 1);
    chk("R9 even address", s_alo, 16'h0200);
    chk("R9 unread lane zero", rdata_done, 16'h00B2);
  endtask

  task automatic t_ready_stretch;
    set_cfg(3'd1, 4'd1, 0, 0, 0, 2'd3);
    xfer(0, 24'h000010, 16'h0, 2'b11, 1, 3, 0);
    chk("R6 stretched strobe", stb_cnt, 5);
    chk("R6 stretched length", n, 6);
  endtask

  task automatic t_single_chip;
    int act = 0;
    set_cfg(3'd0, 4'd0, 0, 0, 0, 2'd3);
    @(negedge clk); req_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (req_done || ale || !rd_n || !wr_n || !req_idle) act++;
    end
    req_valid = 1'b0;
    chk("R1 single-chip quiet", act, 0);
  endtask

  task automatic t_busy_ignored;
    set_cfg(3'd1, 4'd4, 0, 0, 0, 2'd3);
    xfer(0, 24'h001111, 16'h0, 2'b11, 4, 0, 1);
    chk("R10 busy request ignored", pulses, 1);
    chk("R10 latched wait", stb_cnt, 5);
    chk("R10 no follow-on cycle", done_after, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_demux16_read;
    t_mux16_write;
    t_mux8_word_read;
    t_demux8_hi_write;
    t_demux8_lo_read;
    t_ready_stretch;
    t_single_chip;
    t_busy_ignored;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule